// File: doc/BRIEF.md
# Fragmented-Input Crypto DMA Job Controller

This block sits in front of a memory-to-memory cryptographic engine and runs one job at a time. Software programs it over a small 32-bit register bus: a control word, a read address, a byte count, a write address, four mode words and a write-only key store. A start strobe launches the job. The sequencer then reads the input from a word-wide memory port, four 32-bit words (16 bytes) per block, and hands each block to the engine over a valid/ready handshake. It writes each result block back to memory at the write address.

The input does not have to sit in one contiguous buffer. With the more-input control bit set, the controller consumes the current fragment and then parks in a wait state, which is neither running nor finished. Software loads the next fragment's address and count and strobes start again. The job then continues without losing its key, its output position or any result it is holding.

The cipher datapath is outside this block. A stub engine stands in for it: it XORs each input word with the matching key word and models a fixed-length key-expansion phase.

Top module: `cdma_job_ctrl`

## Requirements
- R1: After reset the status word reads 1: idle flag (bit 0) is 1, the wait-for-input flag (bit 1) is 0 and the interrupt flag (bit 2) is 0. The control word reads 0 and the irq output is low.
- R2: Register byte offsets are control 0x00, start 0x04, read address 0x08, byte count 0x0C, write address 0x10, status 0x14, interrupt clear 0x18, mode words 0x1C/0x20/0x24/0x28, and key word k at 0x100+4k. The control bits are: more-input bit 0, irq-enable bit 1, final-block-only bit 2, key-expansion bit 3. The start register always reads 0.
- R3: Each input block is read as words from read address +0, +4, +8, +12 (word k = bits 32k+31:32k). The stub result word k is input word k XOR key word k. Result words are written in order to consecutive write addresses.
- R4: When the remaining byte count ends inside a block, every byte at or beyond the count is replaced by zero before processing. Whole words past the count are not read.
- R5: The read address advances by the bytes consumed, the byte count falls by the same amount, and the write address advances by 4 per word written. After a job they read start+consumed, 0 and start+4*words written.
- R6: With the more-input bit at 0, after the last block is written the idle flag returns to 1.
- R7: With the more-input bit at 1, once the fragment's bytes are consumed the status reads 2 (waiting, not idle). A fragment that ends mid-block is padded as in R4. A start write then resumes with the newly written read address and count, and the write address keeps advancing.
- R8: When irq-enable is set, the end of a job raises irq and status bit 2. Writing 1 to bit 0 of the clear register drops both.
- R9: Key store writes take effect only while the idle flag is 1; writes during a job leave the key unchanged.
- R10: With the final-block-only bit set, only the last result block of the whole job is written, so the write address advances by exactly 16.
- R11: When the key-expansion bit is set at start, the job first runs the expansion phase and the bit reads back 0 after it completes.
- R12: A start write while a job is running and not waiting has no effect on the result or the final register values.
- R13: The memory port issues one word request at a time and never requests in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completed (one cycle after mem_req) |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| irq | output | 1 | Pending interrupt request |

## Verification
Jobs are run with byte counts that are exact block multiples, that end one byte into a word, and that end mid-block. Comparing the result words with the zero-padded expectation separates correct masking from reading or keeping stale bytes. Runs with every block written and runs with only the final block written separate the two output modes. The sentinel words left after the write window show that nothing extra was stored. A two-fragment job whose first fragment ends mid-block shows that the wait state keeps the write position across a resume. Start and key writes made mid-job show that busy-time writes are dropped. Random lengths and data across both modes cover the remaining combinations.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
    localparam int ADDR_W   = 32;
    localparam int WORD_W   = 32;
    localparam int BLK_WRDS = 4;
    localparam int BLK_W    = WORD_W * BLK_WRDS;
    localparam int WIDX_W   = $clog2(BLK_WRDS);

    localparam logic [8:0] OFS_CTRL  = 9'h000;
    localparam logic [8:0] OFS_START = 9'h004;
    localparam logic [8:0] OFS_SRC   = 9'h008;
    localparam logic [8:0] OFS_CNT   = 9'h00C;
    localparam logic [8:0] OFS_DST   = 9'h010;
    localparam logic [8:0] OFS_STAT  = 9'h014;
    localparam logic [8:0] OFS_ICLR  = 9'h018;
    localparam logic [8:0] OFS_MODE0 = 9'h01C;
    localparam logic [8:0] OFS_MODE3 = 9'h028;

    typedef struct packed {
        logic kexp;
        logic last_only;
        logic irq_en;
        logic more_in;
    } ctrl_t;

    typedef enum logic [3:0] {
        S_IDLE, S_KEXP, S_CHECK, S_FETCH, S_FWAIT,
        S_SEND, S_RECV, S_WRITE, S_WWAIT, S_WAITIN
    } seq_state_t;

    function automatic logic [2:0] take_bytes(input logic [23:0] remaining);
        return (remaining >= 24'd4) ? 3'd4 : remaining[2:0];
    endfunction

    function automatic logic [WORD_W-1:0] keep_mask(input logic [2:0] n);
        logic [WORD_W-1:0] m;
        for (int b = 0; b < 4; b++)
            m[8*b +: 8] = (b < int'(n)) ? 8'hFF : 8'h00;
        return m;
    endfunction
endpackage

// File: rtl/cdma_keystore.sv
module cdma_keystore
    import cdma_pkg::*;
#(
    parameter int KEY_WORDS = 16,
    localparam int IDX_W = $clog2(KEY_WORDS)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_en,
    input  logic                        allow,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic [WORD_W-1:0]           wr_data,
    output logic [BLK_WRDS-1:0][WORD_W-1:0] eng_key
);
    logic [KEY_WORDS-1:0][WORD_W-1:0] kq;

    for (genvar i = 0; i < KEY_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst)
                kq[i] <= '0;
            else if (wr_en && allow && wr_idx == IDX_W'(i))
                kq[i] <= wr_data;
        end
    end

    for (genvar k = 0; k < BLK_WRDS; k++) begin : g_out
        assign eng_key[k] = kq[k];
    end

    // R9: a key write outside the idle window never changes the store
    assert_key_locked_R9: assert property (@(posedge clk) disable iff (rst)
        !allow |=> $stable(kq));
endmodule

// File: rtl/cdma_engine_stub.sv
module cdma_engine_stub
    import cdma_pkg::*;
#(
    parameter int KEXP_CYCLES = 4,
    localparam int KC_W = $clog2(KEXP_CYCLES + 1)
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [BLK_WRDS-1:0][WORD_W-1:0]  key,
    input  logic                             kexp_go,
    output logic                             kexp_done,
    input  logic                             in_valid,
    output logic                             in_ready,
    input  logic [BLK_WRDS-1:0][WORD_W-1:0]  in_data,
    output logic                             out_valid,
    input  logic                             out_ready,
    output logic [BLK_WRDS-1:0][WORD_W-1:0]  out_data
);
    logic            full;
    logic [KC_W-1:0] kcnt;

    assign in_ready  = !full;
    assign out_valid = full;
    assign kexp_done = kexp_go && (kcnt == KC_W'(KEXP_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst || !kexp_go)
            kcnt <= '0;
        else if (!kexp_done)
            kcnt <= kcnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            full     <= 1'b0;
            out_data <= '0;
        end else if (in_valid && in_ready) begin
            full <= 1'b1;
            for (int k = 0; k < BLK_WRDS; k++)
                out_data[k] <= in_data[k] ^ key[k];
        end else if (out_ready && full) begin
            full <= 1'b0;
        end
    end
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
    import cdma_pkg::*;
#(
    parameter int LEN_W = 24
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             start,
    input  ctrl_t                            ctrl,
    input  logic                             sw_src_wr,
    input  logic                             sw_cnt_wr,
    input  logic                             sw_dst_wr,
    input  logic [WORD_W-1:0]                sw_wdata,
    output logic [ADDR_W-1:0]                src_q,
    output logic [LEN_W-1:0]                 cnt_q,
    output logic [ADDR_W-1:0]                dst_q,
    output logic                             idle_q,
    output logic                             waiting_q,
    output logic                             job_done,
    output logic                             kexp_clr,
    output logic                             kexp_go,
    input  logic                             kexp_done,
    output logic                             mem_req,
    output logic                             mem_we,
    output logic [ADDR_W-1:0]                mem_addr,
    output logic [WORD_W-1:0]                mem_wdata,
    input  logic                             mem_ack,
    input  logic [WORD_W-1:0]                mem_rdata,
    output logic                             eng_in_valid,
    input  logic                             eng_in_ready,
    output logic [BLK_WRDS-1:0][WORD_W-1:0]  eng_in_data,
    input  logic                             eng_out_valid,
    output logic                             eng_out_ready,
    input  logic [BLK_WRDS-1:0][WORD_W-1:0]  eng_out_data
);
    seq_state_t                      state;
    logic [WIDX_W-1:0]               widx;
    logic                            held;
    logic                            final_q;
    logic [BLK_WRDS-1:0][WORD_W-1:0] blk;
    logic [BLK_WRDS-1:0][WORD_W-1:0] obuf;
    logic [2:0]                      take;
    logic                            sw_open;
    logic                            busy;

    assign take    = take_bytes(24'(cnt_q));
    assign sw_open = (state == S_IDLE) || (state == S_WAITIN);
    assign busy    = !sw_open;

    assign mem_req       = (state == S_FETCH) || (state == S_WRITE);
    assign mem_we        = (state == S_WRITE);
    assign mem_addr      = (state == S_WRITE) ? dst_q : src_q;
    assign mem_wdata     = obuf[widx];
    assign eng_in_valid  = (state == S_SEND);
    assign eng_in_data   = blk;
    assign eng_out_ready = (state == S_RECV);
    assign kexp_go       = (state == S_KEXP);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            src_q     <= '0;
            cnt_q     <= '0;
            dst_q     <= '0;
            idle_q    <= 1'b1;
            waiting_q <= 1'b0;
            job_done  <= 1'b0;
            kexp_clr  <= 1'b0;
            widx      <= '0;
            held      <= 1'b0;
            final_q   <= 1'b0;
            blk       <= '0;
            obuf      <= '0;
        end else begin
            job_done <= 1'b0;
            kexp_clr <= 1'b0;
            if (sw_open) begin
                if (sw_src_wr) src_q <= sw_wdata;
                if (sw_cnt_wr) cnt_q <= sw_wdata[LEN_W-1:0];
                if (sw_dst_wr) dst_q <= sw_wdata;
            end
            case (state)
                S_IDLE: if (start) begin
                    idle_q  <= 1'b0;
                    held    <= 1'b0;
                    final_q <= 1'b0;
                    state   <= ctrl.kexp ? S_KEXP : S_CHECK;
                end
                S_KEXP: if (kexp_done) begin
                    kexp_clr <= 1'b1;
                    state    <= S_CHECK;
                end
                S_CHECK: begin
                    widx <= '0;
                    if (cnt_q != '0) begin
                        blk   <= '0;
                        state <= S_FETCH;
                    end else if (ctrl.more_in) begin
                        waiting_q <= 1'b1;
                        state     <= S_WAITIN;
                    end else if (ctrl.last_only && held) begin
                        final_q <= 1'b1;
                        state   <= S_WRITE;
                    end else begin
                        idle_q   <= 1'b1;
                        job_done <= 1'b1;
                        held     <= 1'b0;
                        state    <= S_IDLE;
                    end
                end
                S_FETCH: state <= S_FWAIT;
                S_FWAIT: if (mem_ack) begin
                    blk[widx] <= mem_rdata & keep_mask(take);
                    src_q     <= src_q + ADDR_W'(take);
                    cnt_q     <= cnt_q - LEN_W'(take);
                    if (widx == WIDX_W'(BLK_WRDS - 1) || cnt_q == LEN_W'(take)) begin
                        state <= S_SEND;
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= S_FETCH;
                    end
                end
                S_SEND: if (eng_in_ready) state <= S_RECV;
                S_RECV: if (eng_out_valid) begin
                    obuf <= eng_out_data;
                    held <= 1'b1;
                    widx <= '0;
                    if (!ctrl.last_only) begin
                        final_q <= 1'b0;
                        state   <= S_WRITE;
                    end else begin
                        state <= S_CHECK;
                    end
                end
                S_WRITE: state <= S_WWAIT;
                S_WWAIT: if (mem_ack) begin
                    dst_q <= dst_q + ADDR_W'(4);
                    if (widx == WIDX_W'(BLK_WRDS - 1)) begin
                        widx <= '0;
                        if (final_q) begin
                            idle_q   <= 1'b1;
                            job_done <= 1'b1;
                            held     <= 1'b0;
                            state    <= S_IDLE;
                        end else begin
                            state <= S_CHECK;
                        end
                    end else begin
                        widx  <= widx + 1'b1;
                        state <= S_WRITE;
                    end
                end
                S_WAITIN: if (start) begin
                    waiting_q <= 1'b0;
                    state     <= S_CHECK;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R7: waiting and idle never hold together
    assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
        !(idle_q && waiting_q));
    // R13: one outstanding word request, never back to back
    assert_one_outstanding_R13: assert property (@(posedge clk) disable iff (rst)
        mem_req |=> !mem_req);
    // R5: the remaining count never grows while a job runs
    assert_count_monotone_R5: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> (cnt_q <= $past(cnt_q)));
    // R12: a start strobe while running leaves the idle flag low
    assert_start_ignored_R12: assert property (@(posedge clk) disable iff (rst)
        (start && busy && state != S_CHECK && state != S_WWAIT) |=> !idle_q);
endmodule

// File: rtl/cdma_job_ctrl.sv
module cdma_job_ctrl
    import cdma_pkg::*;
#(
    parameter int LEN_W       = 24,
    parameter int KEY_WORDS   = 16,
    parameter int KEXP_CYCLES = 4,
    localparam int KIDX_W     = $clog2(KEY_WORDS)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [8:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        irq
);
    ctrl_t                           ctrl_q;
    logic [3:0][WORD_W-1:0]          mode_q;
    logic                            irq_q;
    logic [ADDR_W-1:0]               src_q, dst_q;
    logic [LEN_W-1:0]                cnt_q;
    logic                            idle_q, waiting_q, job_done, kexp_clr;
    logic                            kexp_go, kexp_done;
    logic [BLK_WRDS-1:0][WORD_W-1:0] eng_key, e_in, e_out;
    logic                            e_in_v, e_in_r, e_out_v, e_out_r;
    logic                            key_hit;
    logic                            wr_ctrl, start_p;
    logic [1:0]                      mode_sel;

    assign key_hit  = reg_addr[8] && (reg_addr[7:2] < 6'(KEY_WORDS)) && (reg_addr[1:0] == 2'b00);
    assign wr_ctrl  = reg_wr && reg_addr == OFS_CTRL;
    assign start_p  = reg_wr && reg_addr == OFS_START && reg_wdata[0];
    assign mode_sel = 2'((reg_addr - OFS_MODE0) >> 2);
    assign irq      = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= ctrl_t'(reg_wdata[3:0]);
            else if (kexp_clr)
                ctrl_q.kexp <= 1'b0;
            if (reg_wr && reg_addr >= OFS_MODE0 && reg_addr <= OFS_MODE3 && reg_addr[1:0] == 2'b00)
                mode_q[mode_sel] <= reg_wdata;
            if (job_done && ctrl_q.irq_en)
                irq_q <= 1'b1;
            else if (reg_wr && reg_addr == OFS_ICLR && reg_wdata[0])
                irq_q <= 1'b0;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFS_CTRL: reg_rdata = {28'd0, ctrl_q};
            OFS_SRC:  reg_rdata = src_q;
            OFS_CNT:  reg_rdata = 32'(cnt_q);
            OFS_DST:  reg_rdata = dst_q;
            OFS_STAT: reg_rdata = {29'd0, irq_q, waiting_q, idle_q};
            default: begin
                if (reg_addr >= OFS_MODE0 && reg_addr <= OFS_MODE3 && reg_addr[1:0] == 2'b00)
                    reg_rdata = mode_q[mode_sel];
            end
        endcase
    end

    cdma_keystore #(.KEY_WORDS(KEY_WORDS)) u_keys (
        .clk(clk), .rst(rst),
        .wr_en(reg_wr && key_hit), .allow(idle_q),
        .wr_idx(KIDX_W'(reg_addr[7:2])), .wr_data(reg_wdata),
        .eng_key(eng_key)
    );

    cdma_engine_stub #(.KEXP_CYCLES(KEXP_CYCLES)) u_eng (
        .clk(clk), .rst(rst), .key(eng_key),
        .kexp_go(kexp_go), .kexp_done(kexp_done),
        .in_valid(e_in_v), .in_ready(e_in_r), .in_data(e_in),
        .out_valid(e_out_v), .out_ready(e_out_r), .out_data(e_out)
    );

    cdma_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst), .start(start_p), .ctrl(ctrl_q),
        .sw_src_wr(reg_wr && reg_addr == OFS_SRC),
        .sw_cnt_wr(reg_wr && reg_addr == OFS_CNT),
        .sw_dst_wr(reg_wr && reg_addr == OFS_DST),
        .sw_wdata(reg_wdata),
        .src_q(src_q), .cnt_q(cnt_q), .dst_q(dst_q),
        .idle_q(idle_q), .waiting_q(waiting_q),
        .job_done(job_done), .kexp_clr(kexp_clr),
        .kexp_go(kexp_go), .kexp_done(kexp_done),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .eng_in_valid(e_in_v), .eng_in_ready(e_in_r), .eng_in_data(e_in),
        .eng_out_valid(e_out_v), .eng_out_ready(e_out_r), .eng_out_data(e_out)
    );

    // R8: a request only appears at the end of an enabled job
    assert_irq_source_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_q) |-> ($past(job_done) && $past(ctrl_q.irq_en)));
    // R11: expansion completion drops the request bit
    assert_kexp_cleared_R11: assert property (@(posedge clk) disable iff (rst)
        (kexp_clr && !wr_ctrl) |=> !ctrl_q.kexp);
    // R2: the start register reads back as zero
    assert_start_reads_zero_R2: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == OFS_START) |-> (reg_rdata == 32'd0));
endmodule

// File: tb/test_cdma_job_ctrl.sv
module test_cdma_job_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_WORDS  = 1024;
    localparam logic [31:0] SENT = 32'hDEAD_BEEF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we, mem_ack;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic        irq;

    logic [31:0] mem [MEM_WORDS];
    logic [31:0] kb [4];
    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cdma_job_ctrl i_cdma_job_ctrl (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .irq(irq)
    );

    always_ff @(posedge clk) begin
        mem_ack   <= rst ? 1'b0 : mem_req;
        mem_rdata <= mem[mem_addr[11:2]];
        if (mem_req && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_status(input logic [31:0] want);
        logic [31:0] s;
        for (int i = 0; i < 5000; i++) begin
            rd(9'h014, s);
            if ((s & 32'h3) == want) return;
        end
    endtask

    function automatic logic [31:0] exp_word(input int base, input int flen, input int bi, input int w);
        logic [31:0] v = mem[(base >> 2) + bi*4 + w];
        for (int b = 0; b < 4; b++)
            if (bi*16 + w*4 + b >= flen) v[8*b +: 8] = 8'h00;
        return v ^ kb[w];
    endfunction

    task automatic fill(input int base, input int nwords, input logic rnd);
        for (int i = 0; i < nwords; i++)
            mem[(base >> 2) + i] = rnd ? $urandom : SENT;
    endtask

    task automatic launch(input int src, input int len, input int dst, input logic [3:0] c);
        wr(9'h000, {28'd0, c});
        wr(9'h008, src);
        wr(9'h00C, len);
        wr(9'h010, dst);
        wr(9'h004, 32'd1);
    endtask

    task automatic check_all(input string req, input int src, input int len, input int dst);
        int nb = (len + 15) / 16;
        for (int bi = 0; bi < nb; bi++)
            for (int w = 0; w < 4; w++)
                chk(req, mem[(dst >> 2) + bi*4 + w], exp_word(src, len, bi, w));
        chk(req, mem[(dst >> 2) + nb*4], SENT);
    endtask

    initial begin
        logic [31:0] v;
        void'($urandom(32'd7321));
        kb[0] = 32'h1111_2222; kb[1] = 32'hA5A5_0F0F; kb[2] = 32'h0000_FFFF; kb[3] = 32'h8421_1248;
        for (int i = 0; i < MEM_WORDS; i++) mem[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        rd(9'h014, v); chk("R1 status", v, 32'd1);
        rd(9'h000, v); chk("R1 ctrl", v, 32'd0);
        chk("R1 irq", {31'd0, irq}, 32'd0);

        for (int k = 0; k < 4; k++) wr(9'h100 + 9'(4*k), kb[k]);

        // R2 R3 R5 R6: two full blocks
        fill(32'h100, 16, 1'b1); fill(32'h800, 16, 1'b0);
        launch(32'h100, 32, 32'h800, 4'b0000);
        rd(9'h004, v); chk("R2 start reads 0", v, 32'd0);
        wait_status(32'd1);
        check_all("R3 data", 32'h100, 32, 32'h800);
        rd(9'h008, v); chk("R5 src", v, 32'h120);
        rd(9'h00C, v); chk("R5 cnt", v, 32'd0);
        rd(9'h010, v); chk("R5 dst", v, 32'h820);
        rd(9'h014, v); chk("R6 idle", v, 32'd1);

        // R4 partial: 5 bytes
        fill(32'h800, 8, 1'b0);
        launch(32'h140, 5, 32'h800, 4'b0000);
        wait_status(32'd1);
        check_all("R4 pad", 32'h140, 5, 32'h800);
        rd(9'h008, v); chk("R5 src partial", v, 32'h145);

        // R10 final block only, 48 bytes
        fill(32'h800, 16, 1'b0);
        launch(32'h100, 48, 32'h800, 4'b0100);
        wait_status(32'd1);
        for (int w = 0; w < 4; w++) chk("R10 last block", mem[(32'h800 >> 2) + w], exp_word(32'h100, 48, 2, w));
        chk("R10 no extra", mem[(32'h810 >> 2)], SENT);
        rd(9'h010, v); chk("R10 dst", v, 32'h810);

        // R7 fragments: 20 bytes then 12 bytes
        fill(32'h800, 16, 1'b0);
        launch(32'h100, 20, 32'h800, 4'b0001);
        wait_status(32'd2);
        rd(9'h014, v); chk("R7 waiting", v, 32'd2);
        wr(9'h000, 32'd0);
        wr(9'h008, 32'h200);
        wr(9'h00C, 32'd12);
        wr(9'h004, 32'd1);
        wait_status(32'd1);
        for (int w = 0; w < 4; w++) begin
            chk("R7 frag1 b0", mem[(32'h800 >> 2) + w], exp_word(32'h100, 20, 0, w));
            chk("R7 frag1 b1", mem[(32'h810 >> 2) + w], exp_word(32'h100, 20, 1, w));
            chk("R7 frag2", mem[(32'h820 >> 2) + w], exp_word(32'h200, 12, 0, w));
        end
        rd(9'h010, v); chk("R7 dst", v, 32'h830);

        // R8 interrupt, R12 start ignored, R9 key write ignored
        fill(32'h800, 16, 1'b0);
        launch(32'h100, 32, 32'h800, 4'b0010);
        wr(9'h004, 32'd1);
        wr(9'h100, 32'hFFFF_FFFF);
        wait_status(32'd1);
        check_all("R12 R9 data", 32'h100, 32, 32'h800);
        rd(9'h010, v); chk("R12 dst", v, 32'h820);
        chk("R8 irq", {31'd0, irq}, 32'd1);
        rd(9'h014, v); chk("R8 status", v, 32'd5);
        wr(9'h018, 32'd1);
        chk("R8 cleared", {31'd0, irq}, 32'd0);
        fill(32'h800, 8, 1'b0);
        launch(32'h100, 16, 32'h800, 4'b0000);
        wait_status(32'd1);
        check_all("R9 key kept", 32'h100, 16, 32'h800);

        // R11 key expansion
        fill(32'h800, 8, 1'b0);
        launch(32'h100, 16, 32'h800, 4'b1000);
        wait_status(32'd1);
        rd(9'h000, v); chk("R11 kexp cleared", v, 32'd0);
        check_all("R11 data", 32'h100, 16, 32'h800);

        // random jobs across both output modes
        for (int j = 0; j < 8; j++) begin
            int len = 1 + int'($urandom % 64);
            logic lo = 1'($urandom);
            int nb = (len + 15) / 16;
            fill(32'h300, 16, 1'b1); fill(32'h800, 20, 1'b0);
            launch(32'h300, len, 32'h800, {1'b0, lo, 2'b00});
            wait_status(32'd1);
            if (lo) begin
                for (int w = 0; w < 4; w++) chk("R10 random", mem[(32'h800 >> 2) + w], exp_word(32'h300, len, nb-1, w));
                chk("R10 random end", mem[32'h810 >> 2], SENT);
            end else begin
                check_all("R3 R4 random", 32'h300, len, 32'h800);
            end
            rd(9'h008, v); chk("R5 random src", v, 32'h300 + len);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule